// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block gathers a set of interrupt request lines, latches each rising edge into a sticky per-source flag, and decides when a small CPU core should enter a service routine and at which vector address. Each source carries a flag, an enable and a priority bit. Software writes the enables, the priorities and a control word that holds the mode bit and two global gates. Flags are cleared only through a write-one-to-clear strobe.

There are two operating modes. With the mode bit clear (the reset state), the block runs single-level. The first gate is a global enable. The second gate additionally qualifies the sources that the `PERIPH_MASK` parameter marks as peripheral. Every interrupt uses vector 0x000008. With the mode bit set, the priority bits take effect. The first gate admits high-priority sources, which use vector 0x000008. The second gate admits low-priority sources, which use vector 0x000018.

The CPU acknowledges a request with `take`, which clears the gate that admitted it. It ends a routine with `reti`, which restores that gate. A two-entry level record lets one high-priority routine nest inside one low-priority routine and unwind in the right order.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, flags and enables are all zero, priority bits are all one, and the mode bit and both gates are zero, so `irq_req` is low.
- R2: A rising edge on `src_req[i]` sets `flags[i]` on the next clock whatever the enables and gates hold; a level held high sets it only once.
- R3: A one on `flag_clr[i]` clears `flags[i]`; a set flag otherwise stays set, and a new edge in the same cycle as a clear leaves the flag set.
- R4: In single-level mode (`mode_o`=0), `irq_req` is high when some source has flag and enable set, `gh_o` is set, and the source is either non-peripheral or `gl_o` is set; the vector is 0x000008 and priority bits have no effect.
- R5: In priority mode (`mode_o`=1), a flagged, enabled source with priority 1 requests vector 0x000008 when `gh_o`=1; one with priority 0 requests vector 0x000018 when `gl_o`=1; when both are pending, 0x000008 is presented.
- R6: `take` while `irq_req` is high clears `gh_o` for a vector 0x000008 request and clears `gl_o` for a vector 0x000018 request.
- R7: A high-priority request is taken during a low-priority routine, and a low-priority request is never presented during a high-priority routine, even with `gl_o` set.
- R8: `reti` sets the gate of the innermost open routine (high before low) and closes that routine; with no routine open, it sets `gh_o`.
- R9: `en_wr`, `pri_wr` and `ctl_wr` load the enables, the priority bits, and the control word (bit 0 gate one, bit 1 gate two, bit 2 mode) on the next clock.
- R10: `take` while `irq_req` is low leaves both gates unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | N_SRC | Request lines, rising edge sets the flag |
| flag_clr | input | N_SRC | Write-one-to-clear strobe for flags |
| en_wr | input | 1 | Load enables |
| en_wdata | input | N_SRC | Enable data |
| pri_wr | input | 1 | Load priority bits |
| pri_wdata | input | N_SRC | Priority data, 1 = high |
| ctl_wr | input | 1 | Load control word |
| ctl_wdata | input | 3 | Bit 0 global/high gate, bit 1 peripheral/low gate, bit 2 mode |
| take | input | 1 | CPU accepts the pending request |
| reti | input | 1 | CPU returns from a routine |
| flags | output | N_SRC | Flag state |
| enables | output | N_SRC | Enable state |
| prios | output | N_SRC | Priority state |
| mode_o | output | 1 | Mode bit |
| gh_o | output | 1 | Global/high gate |
| gl_o | output | 1 | Peripheral/low gate |
| irq_req | output | 1 | Request to the CPU |
| irq_vec | output | VEC_W | Vector address, zero when idle |

## Verification
In single-level mode, every source is swept against all four gate combinations with its enable on and off. This separates the peripheral gating from the global gating and shows that the priority bits are ignored. In priority mode, every source is swept with both priority values against all gate combinations, which tells the high path from the low path by the vector. Directed sequences open a low routine, preempt it with a high one, try a low request inside the high routine, and unwind with two returns. They also cover a clear that collides with a new edge, a held level, and an acknowledge with nothing pending.

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int N_SRC = 8,
  parameter logic [N_SRC-1:0] PERIPH_MASK = 'hF0,
  parameter int VEC_W = 24,
  parameter logic [VEC_W-1:0] HI_VEC = 'h000008,
  parameter logic [VEC_W-1:0] LO_VEC = 'h000018
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_req,
  input  logic [N_SRC-1:0] flag_clr,
  input  logic             en_wr,
  input  logic [N_SRC-1:0] en_wdata,
  input  logic             pri_wr,
  input  logic [N_SRC-1:0] pri_wdata,
  input  logic             ctl_wr,
  input  logic [2:0]       ctl_wdata,
  input  logic             take,
  input  logic             reti,
  output logic [N_SRC-1:0] flags,
  output logic [N_SRC-1:0] enables,
  output logic [N_SRC-1:0] prios,
  output logic             mode_o,
  output logic             gh_o,
  output logic             gl_o,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec
);
  logic [N_SRC-1:0] src_q, flag_q, en_q, pri_q;
  logic mode_q, gh_q, gl_q, in_hi, in_lo;

  wire [N_SRC-1:0] rise = src_req & ~src_q;
  wire [N_SRC-1:0] live = flag_q & en_q;
  wire cmp_go = gh_q & (|(live & (~PERIPH_MASK | {N_SRC{gl_q}})));
  wire hi_go  = mode_q ? (gh_q & (|(live & pri_q))) : cmp_go;
  wire lo_go  = mode_q & gl_q & ~in_hi & (|(live & ~pri_q));

  assign irq_req = hi_go | lo_go;
  assign irq_vec = hi_go ? HI_VEC : (lo_go ? LO_VEC : '0);
  assign flags   = flag_q;
  assign enables = en_q;
  assign prios   = pri_q;
  assign mode_o  = mode_q;
  assign gh_o    = gh_q;
  assign gl_o    = gl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q  <= '0;
      flag_q <= '0;
      en_q   <= '0;
      pri_q  <= '1;
      mode_q <= 1'b0;
      gh_q   <= 1'b0;
      gl_q   <= 1'b0;
      in_hi  <= 1'b0;
      in_lo  <= 1'b0;
    end else begin
      src_q  <= src_req;
      flag_q <= (flag_q & ~flag_clr) | rise;
      if (en_wr)  en_q  <= en_wdata;
      if (pri_wr) pri_q <= pri_wdata;
      if (ctl_wr) begin
        gh_q   <= ctl_wdata[0];
        gl_q   <= ctl_wdata[1];
        mode_q <= ctl_wdata[2];
      end
      if (take && irq_req) begin
        if (hi_go) begin
          gh_q  <= 1'b0;
          in_hi <= 1'b1;
        end else begin
          gl_q  <= 1'b0;
          in_lo <= 1'b1;
        end
      end else if (reti) begin
        if (in_hi) begin
          gh_q  <= 1'b1;
          in_hi <= 1'b0;
        end else if (in_lo) begin
          gl_q  <= 1'b1;
          in_lo <= 1'b0;
        end else begin
          gh_q  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int N_SRC = 8,
  parameter int VEC_W = 24,
  parameter logic [VEC_W-1:0] HI_VEC = 'h000008,
  parameter logic [VEC_W-1:0] LO_VEC = 'h000018
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] src_req,
  input logic [N_SRC-1:0] src_q,
  input logic [N_SRC-1:0] flag_clr,
  input logic [N_SRC-1:0] flags,
  input logic             take,
  input logic             reti,
  input logic             mode_o,
  input logic             gh_o,
  input logic             gl_o,
  input logic             in_hi,
  input logic             irq_req,
  input logic [VEC_W-1:0] irq_vec
);
  p_rise_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(src_req) & ~$past(src_q)) & ~flags) == '0));

  p_flag_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(flags) & ~$past(flag_clr)) & ~flags) == '0));

  p_single_vec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_o && irq_req) |-> irq_vec == HI_VEC);

  p_vec_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vec == HI_VEC || irq_vec == LO_VEC));

  p_take_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && irq_req && irq_vec == HI_VEC) |=> !gh_o);

  p_take_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && irq_req && irq_vec == LO_VEC) |=> !gl_o);

  p_no_low_in_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o && in_hi) |-> !(irq_req && irq_vec == LO_VEC));

  p_reti_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !(take && irq_req) && in_hi) |=> (gh_o && !in_hi));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(
  .N_SRC(N_SRC), .VEC_W(VEC_W), .HI_VEC(HI_VEC), .LO_VEC(LO_VEC)
) u_chk (.*);

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam logic [N-1:0] PM = 8'hF0;
  localparam int HV = 'h08;
  localparam int LV = 'h18;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] src_req = '0, flag_clr = '0, en_wdata = '0, pri_wdata = '0;
  logic en_wr = 0, pri_wr = 0, ctl_wr = 0, take = 0, reti = 0;
  logic [2:0] ctl_wdata = '0;
  logic [N-1:0] flags, enables, prios;
  logic mode_o, gh_o, gl_o, irq_req;
  logic [23:0] irq_vec;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_ctrl uut (.*);

  task automatic tick; @(posedge clk); #1; endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_en(input logic [N-1:0] v);
    en_wr = 1; en_wdata = v; tick; en_wr = 0;
  endtask
  task automatic wr_pri(input logic [N-1:0] v);
    pri_wr = 1; pri_wdata = v; tick; pri_wr = 0;
  endtask
  task automatic wr_ctl(input logic m, input logic a, input logic b);
    ctl_wr = 1; ctl_wdata = {m, b, a}; tick; ctl_wr = 0;
  endtask
  task automatic clr(input logic [N-1:0] m);
    flag_clr = m; tick; flag_clr = '0;
  endtask
  task automatic pulse(input int i);
    src_req[i] = 1'b1; tick; src_req[i] = 1'b0; tick;
  endtask
  task automatic do_take; take = 1; tick; take = 0; endtask
  task automatic do_reti; reti = 1; tick; reti = 0; endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) tick;
    rst_n = 1;
    tick;
    chk("R1 flags", flags, 0);
    chk("R1 enables", enables, 0);
    chk("R1 prios", prios, 8'hFF);
    chk("R1 ctl", {mode_o, gl_o, gh_o}, 0);
    chk("R1 irq", irq_req, 0);

    wr_en(8'h5A); chk("R9 en", enables, 8'h5A);
    wr_pri(8'h3C); chk("R9 pri", prios, 8'h3C);
    wr_ctl(1, 1, 0); chk("R9 ctl", {mode_o, gl_o, gh_o}, 3'b101);

    // single-level sweep
    for (int i = 0; i < N; i++)
      for (int g = 0; g < 4; g++)
        for (int e = 0; e < 2; e++) begin
          logic ex;
          clr('1);
          wr_en(e ? N'(1 << i) : '0);
          wr_pri((i % 2) ? 8'h00 : 8'hFF);
          wr_ctl(0, g[0], g[1]);
          pulse(i);
          ex = e[0] & g[0] & (!PM[i] | g[1]);
          chk("R2 flag", flags[i], 1);
          chk("R4 req", irq_req, ex);
          chk("R4 vec", irq_vec, ex ? HV : 0);
        end

    // priority-mode sweep
    for (int i = 0; i < N; i++)
      for (int p = 0; p < 2; p++)
        for (int g = 0; g < 4; g++) begin
          logic ex;
          clr('1);
          wr_en(N'(1 << i));
          wr_pri(p ? N'(1 << i) : '0);
          wr_ctl(1, g[0], g[1]);
          pulse(i);
          ex = p ? g[0] : g[1];
          chk("R5 req", irq_req, ex);
          chk("R5 vec", irq_vec, ex ? (p ? HV : LV) : 0);
        end

    // edge vs clear collision, held level
    clr('1); wr_en('0);
    src_req[2] = 1; flag_clr[2] = 1; tick; flag_clr = '0;
    chk("R3 event wins", flags[2], 1);
    clr(8'h04);
    chk("R3 cleared", flags[2], 0);
    tick;
    chk("R2 held level", flags[2], 0);
    src_req[2] = 0; tick;

    // nesting and preemption: src0 high, src1 low
    clr('1);
    wr_en(8'h03); wr_pri(8'h01); wr_ctl(1, 1, 1);
    pulse(1);
    chk("R5 low vec", irq_vec, LV);
    do_take;
    chk("R6 low gates", {gh_o, gl_o}, 2'b10);
    pulse(0);
    chk("R7 preempt req", irq_req, 1);
    chk("R7 preempt vec", irq_vec, HV);
    do_take;
    chk("R6 high gates", {gh_o, gl_o}, 2'b00);
    clr(8'h01);
    wr_ctl(1, 0, 1);
    chk("R7 no low in high", irq_req, 0);
    wr_ctl(1, 0, 0);
    clr(8'h02);
    do_reti;
    chk("R8 first return", {gh_o, gl_o}, 2'b10);
    do_reti;
    chk("R8 second return", {gh_o, gl_o}, 2'b11);
    pulse(1); pulse(0);
    chk("R5 both pending", irq_vec, HV);
    do_take;
    chk("R6 both take", {gh_o, gl_o}, 2'b01);
    do_reti;
    chk("R8 return high", {gh_o, gl_o}, 2'b11);

    // idle take and empty return
    clr('1);
    wr_ctl(1, 1, 1);
    do_take;
    chk("R10 idle take", {gh_o, gl_o}, 2'b11);
    wr_ctl(0, 0, 1);
    do_reti;
    chk("R8 empty return", gh_o, 1);

    // single-level take/return
    clr('1);
    wr_en(8'h01); wr_ctl(0, 1, 0);
    pulse(0);
    chk("R4 req", irq_req, 1);
    do_take;
    chk("R6 single take", gh_o, 0);
    chk("R6 single req", irq_req, 0);
    clr(8'h01);
    do_reti;
    chk("R8 single return", gh_o, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule